// File: doc/BRIEF.md
# Non-Adjacent Form Digit Recoder

This block turns an unsigned binary integer into its canonical signed-digit form, in which every digit is -1, 0 or +1 and no two non-zero digits sit next to each other. The result is carried on two bit vectors of equal width. One vector flags the positions holding +1. The other flags the positions holding -1. The integer equals the first vector minus the second. Both vectors are one bit wider than the input, so the carry out of the top bit is kept.

The recoding has no digit-by-digit scan. A right shift by one position gives a half value, which is pure wiring. A single adder then sums the input and that half value. An XOR of the half value with the sum gives a mask of the positions that changed. Two ANDs of that mask run side by side: one with the sum gives the +1 digits, and one with the half value gives the -1 digits. The form obtained has the fewest non-zero digits of any signed-digit form of the same value. It therefore never has more than plain radix-2 Booth recoding, which makes it a good operand source for a signed-digit multiplier.

A parameter selects whether the two vectors and a valid flag are registered or passed straight through. By default they are registered.

Top module: `naf_recoder`

## Requirements
- R1: For every input value, the +1 vector minus the -1 vector, taken as unsigned numbers of DATA_W+1 bits, equals the input exactly.
- R2: No bit position is set in both the +1 vector and the -1 vector.
- R3: Between any two non-zero digits there is at least one zero digit: the OR of the two vectors, ANDed with itself shifted by one place, is zero.
- R4: The number of non-zero digits equals the count produced by a serial right-to-left non-adjacent-form scan of the same value, which is the minimum count over all signed-digit forms.
- R5: An input of zero gives both vectors all zero.
- R6: An input of all ones gives a +1 vector with only bit DATA_W set and a -1 vector with only bit 0 set.
- R7: Each output vector is DATA_W+1 bits wide, and a carry out of the input's top bit shows up as +1 at bit DATA_W (for example, the input with only its two top bits set).
- R8: With OUT_MODE set to OUT_REG, the vectors and out_valid show the input and in_valid sampled on the previous rising clock edge. While rst_n is low, out_valid and both vectors are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks in_value as carrying an operand |
| in_value | input | DATA_W | Unsigned integer to recode |
| out_valid | output | 1 | in_valid delayed to line up with the digit vectors |
| pos_digits | output | DATA_W+1 | Bit i set means the digit of weight 2^i is +1 |
| neg_digits | output | DATA_W+1 | Bit i set means the digit of weight 2^i is -1 |

## Verification
In the default registered mode, each operand's two digit vectors and its valid flag appear exactly one rising edge after the operand is driven. Nothing in the block takes more than that single register stage. The bench drives on the falling edge and keeps the operand and valid flag it drove last. At the next falling edge it compares the outputs against a serial scan computed from that kept operand, so every comparison lands on the cycle where the result is due. In idle cycles, where in_valid was low one edge earlier, the bench checks that out_valid has dropped. During reset it checks that all outputs read zero.

// File: rtl/naf_pkg.sv
package naf_pkg;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } naf_out_mode_e;

endpackage

// File: rtl/naf_half_sum.sv
module naf_half_sum #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  output logic [W:0]   half_v,
  output logic [W:0]   sum_v
);
  localparam int OW = W + 1;

  function automatic logic [OW-1:0] f_half(input logic [W-1:0] a);
    return {1'b0, a} >> 1;
  endfunction

  function automatic logic [OW-1:0] f_sum(input logic [W-1:0] a,
                                          input logic [OW-1:0] h);
    return {1'b0, a} + h;
  endfunction

  assign half_v = f_half(x);
  assign sum_v  = f_sum(x, half_v);
endmodule

// File: rtl/naf_digit_split.sv
module naf_digit_split #(
  parameter int W = 16
) (
  input  logic [W:0] half_v,
  input  logic [W:0] sum_v,
  output logic [W:0] pos_v,
  output logic [W:0] neg_v
);
  localparam int OW = W + 1;

  logic [OW-1:0] change_mask;

  function automatic logic [OW-1:0] f_mask(input logic [OW-1:0] h,
                                           input logic [OW-1:0] s);
    return h ^ s;
  endfunction

  assign change_mask = f_mask(half_v, sum_v);
  assign pos_v       = sum_v  & change_mask;
  assign neg_v       = half_v & change_mask;
endmodule

// File: rtl/naf_out_stage.sv
module naf_out_stage
  import naf_pkg::*;
#(
  parameter int            W    = 16,
  parameter naf_out_mode_e MODE = OUT_REG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld_in,
  input  logic [W:0] pos_in,
  input  logic [W:0] neg_in,
  output logic       vld_out,
  output logic [W:0] pos_out,
  output logic [W:0] neg_out
);
  generate
    if (MODE == OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_out <= 1'b0;
          pos_out <= '0;
          neg_out <= '0;
        end else begin
          vld_out <= vld_in;
          pos_out <= pos_in;
          neg_out <= neg_in;
        end
      end
    end else begin : g_comb
      assign vld_out = vld_in;
      assign pos_out = pos_in;
      assign neg_out = neg_in;
    end
  endgenerate
endmodule

// File: rtl/naf_recoder.sv
module naf_recoder
  import naf_pkg::*;
#(
  parameter int            DATA_W   = 16,
  parameter naf_out_mode_e OUT_MODE = OUT_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_value,
  output logic              out_valid,
  output logic [DATA_W:0]   pos_digits,
  output logic [DATA_W:0]   neg_digits
);
  localparam int OW = DATA_W + 1;

  logic [OW-1:0] half_w;
  logic [OW-1:0] sum_w;
  logic [OW-1:0] pos_w;
  logic [OW-1:0] neg_w;
  logic [OW-1:0] nz_w;

  naf_half_sum #(.W(DATA_W)) u_half_sum (
    .x      (in_value),
    .half_v (half_w),
    .sum_v  (sum_w)
  );

  naf_digit_split #(.W(DATA_W)) u_split (
    .half_v (half_w),
    .sum_v  (sum_w),
    .pos_v  (pos_w),
    .neg_v  (neg_w)
  );

  naf_out_stage #(.W(DATA_W), .MODE(OUT_MODE)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_in  (in_valid),
    .pos_in  (pos_w),
    .neg_in  (neg_w),
    .vld_out (out_valid),
    .pos_out (pos_digits),
    .neg_out (neg_digits)
  );

  assign nz_w = pos_digits | neg_digits;

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((pos_digits & neg_digits) == '0));

  assert_non_adjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((nz_w & (nz_w >> 1)) == '0));

  generate
    if (OUT_MODE == OUT_REG) begin : g_reg_checks
      assert_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((pos_digits - neg_digits) == {1'b0, $past(in_value)}));

      assert_zero_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_value == '0) |=> (pos_digits == '0 && neg_digits == '0));

      assert_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_value == '1) |=>
          (pos_digits == {1'b1, {DATA_W{1'b0}}} && neg_digits == OW'(1)));

      assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

      assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    end
  endgenerate
endmodule

// File: tb/naf_recoder_tb.sv
module naf_recoder_tb_top;
  import naf_pkg::*;

  localparam int DATA_W  = 16;
  localparam int OW      = DATA_W + 1;
  localparam int CLK_PER = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_value = '0;
  logic              out_valid;
  logic [OW-1:0]     pos_digits;
  logic [OW-1:0]     neg_digits;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic              prev_valid = 1'b0;
  logic [DATA_W-1:0] prev_value = '0;

  always #(CLK_PER/2) clk = ~clk;

  naf_recoder #(.DATA_W(DATA_W), .OUT_MODE(OUT_REG)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_value   (in_value),
    .out_valid  (out_valid),
    .pos_digits (pos_digits),
    .neg_digits (neg_digits)
  );

  // Serial right-to-left scan: an odd remainder emits 2 - (n mod 4).
  task automatic ref_scan(input longint unsigned v,
                          output logic [OW-1:0] p, output logic [OW-1:0] n,
                          output int nz);
    longint unsigned r;
    p  = '0;
    n  = '0;
    nz = 0;
    r  = v;
    for (int i = 0; i < OW; i++) begin
      if (r[0]) begin
        if (r[1] == 1'b0) begin
          p[i] = 1'b1;
          r = r - 1;
        end else begin
          n[i] = 1'b1;
          r = r + 1;
        end
        nz++;
      end
      r = r >> 1;
    end
  endtask

  task automatic chk(input bit ok, input string req,
                     input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [OW-1:0] ep, en;
    logic [OW-1:0] nz;
    int cnt;
    chk(out_valid == prev_valid, "R8 valid", out_valid, prev_valid);
    if (prev_valid) begin
      ref_scan(longint'(prev_value), ep, en, cnt);
      chk(pos_digits == ep, "R1 pos vector", pos_digits, ep);
      chk(neg_digits == en, "R1 neg vector", neg_digits, en);
      chk((pos_digits - neg_digits) == {1'b0, prev_value}, "R1 value",
          pos_digits - neg_digits, prev_value);
      chk((pos_digits & neg_digits) == '0, "R2 overlap", pos_digits & neg_digits, 0);
      nz = pos_digits | neg_digits;
      chk((nz & (nz >> 1)) == '0, "R3 adjacency", nz, 0);
      chk($countones(nz) == cnt, "R4 weight", $countones(nz), cnt);
      if (prev_value == '0)
        chk(nz == '0, "R5 zero", nz, 0);
      if (prev_value == '1)
        chk(pos_digits == {1'b1, {DATA_W{1'b0}}} && neg_digits == OW'(1),
            "R6 all ones", {pos_digits, neg_digits}, {ep, en});
      if (prev_value[DATA_W-1:DATA_W-2] == 2'b11)
        chk(pos_digits[DATA_W] == 1'b1, "R7 carry digit", pos_digits[DATA_W], 1);
    end
  endtask

  task automatic apply(input logic v, input logic [DATA_W-1:0] val);
    @(negedge clk);
    check_outputs();
    in_valid   = v;
    in_value   = val;
    prev_valid = v;
    prev_value = val;
  endtask

  initial begin : stim
    int unsigned lfsr = 32'hACE1_2468;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
    chk(pos_digits == '0 && neg_digits == '0, "R8 reset vectors",
        pos_digits | neg_digits, 0);
    rst_n = 1'b1;
    apply(1'b1, '0);                     // R5
    apply(1'b1, '1);                     // R6
    apply(1'b1, DATA_W'(1));
    apply(1'b1, DATA_W'(2));
    apply(1'b1, DATA_W'(3));
    apply(1'b0, DATA_W'(3));             // R8 idle gap
    apply(1'b1, {DATA_W/2{2'b01}});
    apply(1'b1, {DATA_W/2{2'b10}});
    apply(1'b1, {2'b11, {(DATA_W-2){1'b0}}}); // R7
    apply(1'b1, {1'b0, {(DATA_W-1){1'b1}}});
    apply(1'b1, {1'b1, {(DATA_W-1){1'b0}}});
    for (int i = 0; i < DATA_W; i++) apply(1'b1, DATA_W'(1) << i);
    for (int i = 0; i < DATA_W; i++) apply(1'b1, ~(DATA_W'(1) << i));
    for (int i = 0; i < 3000; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      apply(lfsr[31:29] != 3'b000, lfsr[DATA_W-1:0]);
    end
    apply(1'b0, '0);
    apply(1'b0, '0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PER * 100000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule